// File: doc/BRIEF.md
# Two-Wire Serial Register Target

This block is a target on a two-wire serial bus (I2C). An external controller uses it to read and write a small bank of 8-bit registers. Both bus lines are sampled by the system clock through synchronizers. SDA is driven open-drain: the block only ever pulls it low, through an output-enable. SCL is never held, so the clock is not stretched. The low three bits of the target address come from a configuration input, which gives one of eight addresses on a shared bus. The register contents are also presented on a flat output for the surrounding logic.

A write frame carries a pointer byte and then zero or more data bytes, which go to consecutive registers. A read uses a repeated START after the pointer byte, or simply reads from wherever the pointer stands. Two inputs, one saying the device has finished booting and one saying it is busy, decide whether the block acknowledges its own address.

The protocol engine moves through these states:
- `ST_IDLE` waits for a START.
- `ST_ADDR` collects the address and direction bit. On a hit it goes to `ST_ADDR_ACK`; on a miss, or when not ready, it goes to `ST_IGNORE`.
- `ST_ADDR_ACK` drives the acknowledge bit. It then moves to `ST_PTR` for a write or `ST_RDATA` for a read.
- `ST_PTR` moves to `ST_PTR_ACK`, and `ST_PTR_ACK` moves to `ST_WDATA`.
- `ST_WDATA` moves to `ST_WDATA_ACK`, and `ST_WDATA_ACK` goes back to `ST_WDATA`.
- `ST_RDATA` moves to `ST_RACK`. There, a controller ACK leads to `ST_RNEXT` and then back to `ST_RDATA`. A NACK leads to `ST_IGNORE`.
- A START in any state goes to `ST_ADDR`, and a STOP in any state goes to `ST_IDLE`.

Top module: `i2c_reg_target`

## Requirements
- R1: While reset is asserted and after it is released, SDA is not driven (`sda_oe_o` = 0) and every register reads 0x00.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. After a START the block takes 7 address bits (MSB first) and a direction bit (0 = write, 1 = read). It pulls SDA low in the ninth bit only when the address equals its own.
- R3: The block's own address is `{BASE_HI, addr_sel_i}`. With the default `BASE_HI` = 4'hA, `addr_sel_i` = 3 gives 0x53 and `addr_sel_i` = 6 gives 0x56.
- R4: In a write frame, the first byte after the address loads the 8-bit pointer. Each later byte is stored into the register the pointer names. Every one of these bytes is acknowledged.
- R5: The pointer increases by one after each acknowledged write byte, including the only byte of a single write. Later bytes of the same frame land in consecutive registers.
- R6: After the address with the direction bit set to 1, the block shifts out the register at the pointer, MSB first.
- R7: During a read, a controller ACK advances the pointer and the next register is sent. A controller NACK ends the driving, and the pointer is not advanced.
- R8: `sda_oe_o` changes only while SCL is low. An ACK or data bit is held from one SCL falling edge to the next. SCL is an input only.
- R9: The block does not acknowledge its address while `busy_i` is 1 or `boot_done_i` is 0, and such a frame changes no register.
- R10: Pointer values at or above `NUM_REGS` (default 8) are acknowledged on write but the data is discarded. Reads from them return 0x00.
- R11: The pointer wraps from 0xFF to 0x00.
- R12: A START or STOP in the middle of a byte abandons it: a partly received data byte is not stored, and a START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| addr_sel_i | input | 3 | Low bits of the target address |
| boot_done_i | input | 1 | 1 once the device has finished booting |
| busy_i | input | 1 | 1 while the device cannot take a transaction |
| regs_o | output | NUM_REGS*8 | Register contents, register i at bits [8i+7:8i] |

## Verification
A wrong engine state shows up first on `sda_oe_o`. A missing or extra acknowledge, or a wrong read bit, is visible within the same SCL bit cell. It is sampled in the SCL high phase of that cell. A wrong pointer does not show at once. It surfaces in the next read byte, or in the next write as the wrong register changing on `regs_o`. The bench compares `regs_o` against its model on every clock between frames, so such a write is caught within one clock after the frame ends.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int DATA_W = 8;
    localparam int PTR_W  = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_RNEXT,
        ST_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [PTR_W-1:0]           ptr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] bank [NUM_REGS];

    generate
        for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bank[gi] <= '0;
                end else if (wr_en && (ptr == PTR_W'(gi))) begin
                    bank[gi] <= wr_data;
                end
            end
            assign regs_flat[gi*DATA_W +: DATA_W] = bank[gi];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ptr == PTR_W'(i)) rd_data = bank[i];
        end
    end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [3:0] BASE_HI = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        addr_sel,
    input  logic              boot_done,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic [PTR_W-1:0]  ptr
);
    tgt_state_e        state, state_nx;
    logic [2:0]        bitcnt;
    logic [DATA_W-1:0] shreg;
    logic              ack_drv;
    logic              rw;
    logic              byte_done;
    logic              addr_hit;
    logic [6:0]        own_addr;
    logic [DATA_W-1:0] rx_byte;

    assign own_addr  = {BASE_HI, addr_sel};
    assign byte_done = scl_rise && (bitcnt == 3'd7);
    assign rx_byte   = {shreg[DATA_W-2:0], sda_s};
    assign addr_hit  = (shreg[6:0] == own_addr) && boot_done && !busy;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall && ack_drv) state_nx = rw ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall && ack_drv) state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall && ack_drv) state_nx = ST_WDATA;
                ST_RDATA:     if (scl_fall && (bitcnt == 3'd7)) state_nx = ST_RACK;
                ST_RACK:      if (scl_rise) state_nx = sda_s ? ST_IGNORE : ST_RNEXT;
                ST_RNEXT:     if (scl_fall) state_nx = ST_RDATA;
                ST_IGNORE:    state_nx = ST_IGNORE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            shreg   <= '0;
            ack_drv <= 1'b0;
            rw      <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            ptr     <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                bitcnt  <= '0;
                ack_drv <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                bitcnt  <= '0;
                ack_drv <= 1'b0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= rx_byte;
                            bitcnt <= bitcnt + 3'd1;
                            if (byte_done) begin
                                rw      <= sda_s;
                                ack_drv <= 1'b0;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (!ack_drv) begin
                                sda_oe  <= 1'b1;
                                ack_drv <= 1'b1;
                            end else begin
                                ack_drv <= 1'b0;
                                bitcnt  <= '0;
                                if (rw) begin
                                    shreg  <= rd_data;
                                    sda_oe <= ~rd_data[DATA_W-1];
                                end else begin
                                    sda_oe <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_PTR: begin
                        if (scl_rise) begin
                            shreg  <= rx_byte;
                            bitcnt <= bitcnt + 3'd1;
                            if (byte_done) begin
                                ptr     <= rx_byte;
                                ack_drv <= 1'b0;
                            end
                        end
                    end
                    ST_PTR_ACK: begin
                        if (scl_fall) begin
                            if (!ack_drv) begin
                                sda_oe  <= 1'b1;
                                ack_drv <= 1'b1;
                            end else begin
                                sda_oe  <= 1'b0;
                                ack_drv <= 1'b0;
                                bitcnt  <= '0;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= rx_byte;
                            bitcnt <= bitcnt + 3'd1;
                            if (byte_done) begin
                                wr_en   <= 1'b1;
                                wr_data <= rx_byte;
                                ack_drv <= 1'b0;
                            end
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            if (!ack_drv) begin
                                sda_oe  <= 1'b1;
                                ack_drv <= 1'b1;
                            end else begin
                                sda_oe  <= 1'b0;
                                ack_drv <= 1'b0;
                                bitcnt  <= '0;
                                ptr     <= ptr + 8'd1;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                sda_oe <= 1'b0;
                            end else begin
                                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                                sda_oe <= ~shreg[DATA_W-2];
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise && !sda_s) ptr <= ptr + 8'd1;
                    end
                    ST_RNEXT: begin
                        if (scl_fall) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[DATA_W-1];
                            bitcnt <= '0;
                        end
                    end
                    ST_IDLE, ST_IGNORE: begin
                        sda_oe <= 1'b0;
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] BASE_HI     = 4'hA
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    input  logic [2:0]                 addr_sel_i,
    input  logic                       boot_done_i,
    input  logic                       busy_i,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_en_w;
    logic [DATA_W-1:0] wr_data_w;
    logic [DATA_W-1:0] rd_data_w;
    logic [PTR_W-1:0]  ptr_w;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.BASE_HI(BASE_HI)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel_i),
        .boot_done (boot_done_i),
        .busy      (busy_i),
        .rd_data   (rd_data_w),
        .sda_oe    (sda_oe_o),
        .wr_en     (wr_en_w),
        .wr_data   (wr_data_w),
        .ptr       (ptr_w)
    );

    i2c_tgt_regs #(.NUM_REGS(NUM_REGS)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_w),
        .ptr       (ptr_w),
        .wr_data   (wr_data_w),
        .rd_data   (rd_data_w),
        .regs_flat (regs_o)
    );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
    parameter int REG_BITS = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_i,
    input logic                sda_oe_o,
    input logic                wr_en,
    input logic [REG_BITS-1:0] regs_o
);
    // R1: reset leaves the bus released and the bank cleared
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe_o && (regs_o == '0)));

    // R8: the data line is only changed while the bus clock is low
    assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R5: registers only take new values inside an SCL high phase
    assert_reg_update_scl_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> scl_i);

    // R4: a store never coincides with the target driving the line
    assert_write_not_driving_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sda_oe_o);
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.REG_BITS(NUM_REGS*8)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .wr_en    (wr_en_w),
    .regs_o   (regs_o)
);

// File: tb/i2c_reg_target_tb_top.sv
`timescale 1ns/1ps
module i2c_reg_target_tb_top;
    localparam int NREG = 8;
    localparam int H    = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scl = 1'b1;
    logic             sda_drv = 1'b1;
    logic             sda_line;
    logic             sda_oe;
    logic [2:0]       addr_sel = 3'd3;
    logic             boot_done = 1'b1;
    logic             busy = 1'b0;
    logic [NREG*8-1:0] regs;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  cmp_en = 1'b0;
    bit  finished = 1'b0;

    logic [7:0] mreg [NREG];
    int         mptr = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    i2c_reg_target dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .addr_sel_i  (addr_sel),
        .boot_done_i (boot_done),
        .busy_i      (busy),
        .regs_o      (regs)
    );

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model between frames
    always @(negedge clk) begin
        if (cmp_en && rst_n && !finished) begin
            for (int i = 0; i < NREG; i++) begin
                n_cmp++;
                if (regs[i*8 +: 8] !== mreg[i]) begin
                    n_bad++;
                    $display("FAIL R4 reg%0d: actual 0x%0h expected 0x%0h", i, regs[i*8 +: 8], mreg[i]);
                end
            end
            n_cmp++;
            if (sda_oe !== 1'b0) begin
                n_bad++;
                $display("FAIL R8 idle drive: actual %0b expected 0", sda_oe);
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        cmp_en = 1'b0;
        wait_clk(3);
        sda_drv = 1'b1; wait_clk(H);
        scl = 1'b1;     wait_clk(H);
        sda_drv = 1'b0; wait_clk(H);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(3);
        sda_drv = 1'b0; wait_clk(H);
        scl = 1'b1;     wait_clk(H);
        sda_drv = 1'b1; wait_clk(H);
        cmp_en = 1'b1;
        wait_clk(4);
    endtask

    task automatic send_bit(logic b);
        wait_clk(3);
        sda_drv = b; wait_clk(H);
        scl = 1'b1;  wait_clk(H);
        scl = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        wait_clk(3);
        sda_drv = 1'b1; wait_clk(H);
        scl = 1'b1;     wait_clk(H/2);
        b = sda_line;   wait_clk(H - H/2);
        scl = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] d, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        acked = !a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(!give_ack);
    endtask

    function automatic logic [7:0] model_rd(int p);
        return (p < NREG) ? mreg[p] : 8'h00;
    endfunction

    task automatic wr_txn(string req, logic [6:0] a, logic [7:0] p, logic [7:0] data[$], bit exp_ack);
        bit ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        check({req, " addr ack"}, ack, exp_ack);
        if (ack) begin
            send_byte(p, ack);
            check({req, " ptr ack"}, ack, 1);
            mptr = p;
            foreach (data[k]) begin
                send_byte(data[k], ack);
                check({req, " data ack"}, ack, 1);
                if (mptr < NREG) mreg[mptr] = data[k];
                mptr = (mptr + 1) & 8'hFF;
            end
        end
        bus_stop();
    endtask

    task automatic rd_body(string req, int n);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            recv_byte(d, i < n - 1);
            check(req, d, model_rd(mptr));
            if (i < n - 1) mptr = (mptr + 1) & 8'hFF;
        end
    endtask

    task automatic rd_set(string req, logic [6:0] a, logic [7:0] p, int n);
        bit ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        check({req, " addr ack"}, ack, 1);
        send_byte(p, ack);
        check({req, " ptr ack"}, ack, 1);
        mptr = p;
        bus_start();
        send_byte({a, 1'b1}, ack);
        check({req, " rd addr ack"}, ack, 1);
        rd_body(req, n);
        bus_stop();
    endtask

    task automatic rd_cur(string req, logic [6:0] a, int n, bit exp_ack);
        bit ack;
        bus_start();
        send_byte({a, 1'b1}, ack);
        check({req, " rd addr ack"}, ack, exp_ack);
        if (ack) rd_body(req, n);
        bus_stop();
    endtask

    initial begin : watchdog
        wait_clk(190000);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        bit ack;
        for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
        wait_clk(5);
        check("R1 oe in reset", sda_oe, 0);
        check("R1 regs in reset", int'(regs == '0), 1);
        rst_n = 1'b1;
        wait_clk(5);
        check("R1 oe after reset", sda_oe, 0);
        cmp_en = 1'b1;

        // R4 R5: sequential write, own address 0x53
        wr_txn("R4", 7'h53, 8'h02, '{8'h11, 8'h22, 8'h33}, 1);
        wr_txn("R5", 7'h53, 8'h06, '{8'h66}, 1);
        // R6 R7: sequential read via repeated start
        rd_set("R6 R7", 7'h53, 8'h02, 3);
        // R5: single write then read from the advanced pointer
        wr_txn("R5", 7'h53, 8'h05, '{8'hA5}, 1);
        rd_cur("R5 ptr after single write", 7'h53, 1, 1);
        // R7: NACK ended read left pointer at last byte
        rd_cur("R7 no advance on NACK", 7'h53, 2, 1);
        // R2: foreign address ignored
        wr_txn("R2 foreign", 7'h52, 8'h00, '{8'hEE}, 0);
        rd_cur("R2 foreign read", 7'h5B, 1, 0);
        // R3: select input moves the address
        addr_sel = 3'd6;
        wr_txn("R3 new addr", 7'h56, 8'h00, '{8'h0F}, 1);
        wr_txn("R3 old addr", 7'h53, 8'h01, '{8'hBB}, 0);
        // R9: busy and not-booted
        busy = 1'b1;
        wr_txn("R9 busy", 7'h56, 8'h01, '{8'hCC}, 0);
        busy = 1'b0;
        boot_done = 1'b0;
        wr_txn("R9 no boot", 7'h56, 8'h01, '{8'hCC}, 0);
        rd_cur("R9 no boot read", 7'h56, 1, 0);
        boot_done = 1'b1;
        // R10: unimplemented location
        wr_txn("R10", 7'h56, 8'h40, '{8'h99}, 1);
        rd_set("R10 read zero", 7'h56, 8'h40, 1);
        // R11: wrap from 0xFF
        wr_txn("R11", 7'h56, 8'hFF, '{8'h77, 8'h88}, 1);
        rd_set("R11 read wrap", 7'h56, 8'hFF, 2);
        // R12: STOP inside a data byte discards it
        bus_start();
        send_byte({7'h56, 1'b0}, ack);
        check("R12 addr ack", ack, 1);
        send_byte(8'h07, ack);
        check("R12 ptr ack", ack, 1);
        mptr = 7;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        rd_cur("R12 after stop", 7'h56, 1, 1);
        // R12: START inside a data byte starts a new address phase
        bus_start();
        send_byte({7'h56, 1'b0}, ack);
        check("R12 addr ack 2", ack, 1);
        send_byte(8'h03, ack);
        check("R12 ptr ack 2", ack, 1);
        mptr = 3;
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_start();
        send_byte({7'h56, 1'b1}, ack);
        check("R12 restart ack", ack, 1);
        rd_body("R12 restart read", 1);
        bus_stop();

        wait_clk(20);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule